// File: doc/BRIEF.md
# Trigger Source Selection with Busy Rejection

This block forms the acquisition trigger of a detector system from four trigger sources that are already synchronous to its clock: a singles source that passes through a loadable one-in-N prescaler, a coincidence source, and two external sources. Each source is reduced to its rising edge, so a long pulse counts once. A per-source enable mask picks which edges may form the raw trigger, which is the registered OR of the enabled edges.

The raw trigger is accepted as a live trigger only while the busy flag is low. Busy is set by the raw trigger after a fixed delay of two clock cycles, which is 50 ns at the intended 40 MHz clock. Busy then holds off all further events until the host sends a clear pulse. Each live trigger ORs its source pattern into a trigger word and raises a held event request for the host. The same host clear drops busy, the trigger word and the event request.

Top module: `trig_sel_busy`

## Requirements
- R1: A source held high for many cycles produces only one raw trigger. The source must return low before it can trigger again.
- R2: Source bit 0 is the prescaled singles input, bit 1 is coincidence, bit 2 is external 1 and bit 3 is external 2. Mask bit i enables source i. rawTrig is high in the cycle after a cycle in which at least one enabled source shows a rising edge. A masked source never raises rawTrig.
- R3: liveTrig is high exactly when rawTrig is high and busy is low.
- R4: A raw trigger in cycle t sets busy from cycle t+2 onward. Busy then stays high until a host clear.
- R5: A hostClr in cycle c makes busy, trigWord and evtReq low in cycle c+1. The clear takes priority over a concurrent set. It also discards any busy set still pending from raw triggers in cycle c or earlier.
- R6: In each live trigger, the enabled source pattern that caused it is ORed into trigWord, using the bit order of R2. Raw triggers blocked by busy leave trigWord unchanged.
- R7: evtReq goes high in the cycle after a live trigger and stays high until a host clear.
- R8: With divisor N of 2 or more, the singles source passes its N-th, 2N-th, and so on rising edges. N of 0 or 1 passes every edge. The prescaler counts singles edges whether or not singles is enabled.
- R9: A scaleLoad cycle sets N to scaleVal and restarts the prescaler count. A singles edge that arrives in that same cycle is discarded.
- R10: After reset, all outputs are low and N is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (40 MHz intended) |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 4 | Synchronized trigger sources, order as in R2 |
| enMask | input | 4 | Per-source enable |
| scaleLoad | input | 1 | Load strobe for the singles divisor |
| scaleVal | input | 8 | Singles divisor N |
| hostClr | input | 1 | Host clear pulse |
| rawTrig | output | 1 | Raw trigger |
| liveTrig | output | 1 | Accepted trigger |
| busy | output | 1 | Busy latch |
| trigWord | output | 4 | Accumulated source pattern of the event |
| evtReq | output | 1 | Held event request |

## Verification
If the busy latch is set wrongly, it shows at liveTrig at once and at evtReq one cycle later. A latch that is set too early or too late also changes whether the second raw pulse of a two-source event is counted. A prescaler count that is off by one shows as a missing or extra rawTrig on the very next singles edge. A trigger word or request that survives a clear shows in the first cycle after hostClr.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic liveStb;
    logic clrStb;
  } ctrl_stb_t;

  localparam int SRC_SINGLES = 0;
endpackage

// File: rtl/trig_dp.sv
module trig_dp
  import trig_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int SCW  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcIn,
  input  logic [NSRC-1:0] enMask,
  input  logic            scaleLoad,
  input  logic [SCW-1:0]  scaleVal,
  input  ctrl_stb_t       stb,
  output logic            rawTrig,
  output logic [NSRC-1:0] trigWord,
  output logic            evtReq
);
  localparam int CW = SCW + 1;

  logic [NSRC-1:0] prevQ, hitQ, rise, qual;
  logic [SCW-1:0]  divQ, cntQ;
  logic            passS;

  assign rise = srcIn & ~prevQ;

  // prescaler decision for the singles edge
  always_comb begin
    passS = 1'b0;
    if (!scaleLoad && rise[SRC_SINGLES])
      passS = (CW'(cntQ) + CW'(1)) >= CW'(divQ);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_qual
    if (i == SRC_SINGLES) begin : g_scaled
      assign qual[i] = passS & enMask[i];
    end else begin : g_direct
      assign qual[i] = rise[i] & enMask[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ    <= '0;
      hitQ     <= '0;
      divQ     <= SCW'(1);
      cntQ     <= '0;
      trigWord <= '0;
      evtReq   <= 1'b0;
    end else begin
      prevQ <= srcIn;
      hitQ  <= qual;
      if (scaleLoad) begin
        divQ <= scaleVal;
        cntQ <= '0;
      end else if (rise[SRC_SINGLES]) begin
        cntQ <= passS ? '0 : cntQ + SCW'(1);
      end
      if (stb.clrStb) begin
        trigWord <= '0;
        evtReq   <= 1'b0;
      end else if (stb.liveStb) begin
        trigWord <= trigWord | hitQ;
        evtReq   <= 1'b1;
      end
    end
  end

  assign rawTrig = |hitQ;

  // R1
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitQ & $past(hitQ)) == '0);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtReq && !stb.clrStb |=> evtReq);
  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStb |=> (evtReq == 1'b0) && (trigWord == '0));
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int SET_DLY = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostClr,
  input  logic      rawTrig,
  output logic      busy,
  output logic      liveTrig,
  output ctrl_stb_t stb
);
  localparam int PIPE = (SET_DLY > 1) ? SET_DLY - 1 : 0;

  logic setReq;

  if (PIPE == 0) begin : g_direct
    assign setReq = rawTrig;
  end else begin : g_pipe
    logic [PIPE-1:0] dlyQ;
    always_ff @(posedge clk) begin
      if (!rstN || hostClr) dlyQ <= '0;
      else if (PIPE == 1)   dlyQ <= rawTrig;
      else                  dlyQ <= {dlyQ[PIPE-2+(PIPE==1):0], rawTrig};
    end
    assign setReq = dlyQ[PIPE-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN || hostClr) busy <= 1'b0;
    else if (setReq)      busy <= 1'b1;
  end

  assign liveTrig    = rawTrig & ~busy;
  assign stb.liveStb = liveTrig;
  assign stb.clrStb  = hostClr;

  // R5
  clr_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostClr |=> !busy);
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !hostClr |=> busy);
endmodule

// File: rtl/trig_sel_busy.sv
module trig_sel_busy
  import trig_pkg::*;
#(
  parameter int NSRC    = 4,
  parameter int SCW     = 8,
  parameter int SET_DLY = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcIn,
  input  logic [NSRC-1:0] enMask,
  input  logic            scaleLoad,
  input  logic [SCW-1:0]  scaleVal,
  input  logic            hostClr,
  output logic            rawTrig,
  output logic            liveTrig,
  output logic            busy,
  output logic [NSRC-1:0] trigWord,
  output logic            evtReq
);
  ctrl_stb_t stb;

  trig_dp #(.NSRC(NSRC), .SCW(SCW)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .enMask(enMask),
    .scaleLoad(scaleLoad), .scaleVal(scaleVal), .stb(stb),
    .rawTrig(rawTrig), .trigWord(trigWord), .evtReq(evtReq)
  );

  trig_ctrl #(.SET_DLY(SET_DLY)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostClr(hostClr), .rawTrig(rawTrig),
    .busy(busy), .liveTrig(liveTrig), .stb(stb)
  );
endmodule

// File: tb/trig_sel_busy_tb.sv
module trig_sel_busy_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] srcIn = '0, enMask = 4'hF;
  logic       scaleLoad = 1'b0, hostClr = 1'b0;
  logic [7:0] scaleVal = '0;
  logic       rawTrig, liveTrig, busy, evtReq;
  logic [3:0] trigWord;

  int checks = 0, errors = 0, rawCnt = 0;
  bit done = 0;

  // reference model state
  logic [3:0] mPrev = '0, mHit = '0, mWord = '0;
  logic       mBusy = 0, mR1 = 0, mReq = 0;
  int         mDiv = 1, mCnt = 0;

  always #5 clk = ~clk;

  trig_sel_busy u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .enMask(enMask),
    .scaleLoad(scaleLoad), .scaleVal(scaleVal), .hostClr(hostClr),
    .rawTrig(rawTrig), .liveTrig(liveTrig), .busy(busy),
    .trigWord(trigWord), .evtReq(evtReq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    logic [3:0] rise, qual;
    logic       pass, raw, live;
    rise = srcIn & ~mPrev;
    pass = 0;
    if (scaleLoad) begin
      mDiv = int'(scaleVal); mCnt = 0;
    end else if (rise[0]) begin
      if (mCnt + 1 >= mDiv) begin pass = 1; mCnt = 0; end
      else mCnt++;
    end
    qual = {rise[3:1], pass} & enMask;
    raw  = |mHit;
    live = raw & ~mBusy;
    if (hostClr) begin
      mWord = '0; mReq = 0; mBusy = 0; mR1 = 0;
    end else begin
      if (live) begin mWord = mWord | mHit; mReq = 1; end
      mBusy = mBusy | mR1;
      mR1   = raw;
    end
    mHit  = qual;
    mPrev = srcIn;
  endtask

  task automatic compareAll();
    logic raw;
    raw = |mHit;
    chk("R2 rawTrig", int'(rawTrig), int'(raw));
    chk("R3 liveTrig", int'(liveTrig), int'(raw & ~mBusy));
    chk("R4 busy", int'(busy), int'(mBusy));
    chk("R6 trigWord", int'(trigWord), int'(mWord));
    chk("R7 evtReq", int'(evtReq), int'(mReq));
    if (rawTrig) rawCnt++;
  endtask

  task automatic step(input logic [3:0] s, input logic clr = 0,
                      input logic ld = 0, input logic [7:0] v = 0);
    srcIn = s; hostClr = clr; scaleLoad = ld; scaleVal = v;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(4'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1 (run finished)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    chk("R10 reset raw", int'(rawTrig), 0);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset word", int'(trigWord), 0);
    chk("R10 reset req", int'(evtReq), 0);

    // R1: long coincidence pulse gives a single raw trigger
    rawCnt = 0;
    for (int i = 0; i < 6; i++) step(4'b0010);
    idle(4);
    chk("R1 raw pulses", rawCnt, 1);
    chk("R4 busy held", int'(busy), 1);
    chk("R6 word coinc", int'(trigWord), 4'b0010);
    // R3 R6: source during busy is blocked and ignored
    step(4'b0100); idle(3);
    chk("R6 word unchanged when busy", int'(trigWord), 4'b0010);
    chk("R7 req held", int'(evtReq), 1);
    step(4'h0, 1);
    chk("R5 busy cleared", int'(busy), 0);
    chk("R5 word cleared", int'(trigWord), 0);
    idle(2);

    // R6: two sources one cycle apart both land in the window
    step(4'b0100); step(4'b1000); idle(4);
    chk("R6 word two sources", int'(trigWord), 4'b1100);
    step(4'h0, 1); idle(2);

    // R5: clear while raw is high discards pending set
    step(4'b0010); step(4'h0, 1); idle(4);
    chk("R5 clear flushes pending set", int'(busy), 0);
    chk("R5 req after clear", int'(evtReq), 0);

    // R2: masked singles never triggers
    enMask = 4'b1110; rawCnt = 0;
    step(4'b0001); idle(3);
    chk("R2 masked source", rawCnt, 0);
    enMask = 4'hF;

    // R8 R9: divisor 3 gives two passes in six edges
    step(4'h0, 1, 1, 8'd3); rawCnt = 0;
    for (int i = 0; i < 6; i++) begin step(4'b0001); step(4'h0, 1); end
    idle(2);
    chk("R8 one in three", rawCnt, 2);

    // R9: edge in the load cycle is discarded
    rawCnt = 0;
    step(4'b0001, 0, 1, 8'd1); step(4'h0); idle(2);
    chk("R9 edge at load dropped", rawCnt, 0);
    step(4'b0001); step(4'h0, 1); idle(2);
    chk("R9 next edge passes", rawCnt, 1);

    // R8: divisor 0 passes every edge
    step(4'h0, 1, 1, 8'd0); rawCnt = 0;
    for (int i = 0; i < 3; i++) begin step(4'b0001); step(4'h0, 1); end
    idle(2);
    chk("R8 divisor zero", rawCnt, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule